// File: doc/BRIEF.md
# Pin Port with Peripheral Override Control

This block is an eight-pin general-purpose I/O port. Software sets each pin's direction and its output level, or its pull-up request when the pin is an input, through two registers on a small register bus. A third register holds the synchronized pin levels and is read-only. Peripheral modules sit beside the port. For each pin, a peripheral can take control of the pull-up, the output-driver enable, the driven value and the digital-input enable, using an enable/value pair for each. A peripheral can also invert the stored output bit of a pin.

A pull-up disable and a sleep flag apply to the whole port. Each pin's input passes through an input gate. The gated level goes straight to the peripherals as a raw tap. The same level also passes through a synchronizer chain before it reaches the readable register. Each pad is modelled as an output value, an output enable, a pull-up request and an input bit.

Top module: `altpin_port`

## Requirements
- R1: With the pull-up override enable low, a pin's pull-up request is 1 exactly when its direction bit is 0, its port bit is 1 and the shared pull-up disable is 0.
- R2: With the pull-up override enable high, the pull-up request equals the pull-up override value, whatever the direction, port and disable bits are.
- R3: The output enable equals the direction override value when the direction override enable is high. Otherwise it equals the direction register bit.
- R4: The driven value equals the value override value when the value override enable is high. Otherwise it equals the port register bit.
- R5: On each clock edge where a pin's toggle request is high and no bus write targets the port register, that pin's port bit inverts.
- R6: A bus write to the port register stores the written data, even when toggle requests are high in the same cycle.
- R7: With the input-enable override enable high, the digital input is gated by the override value. Otherwise it is enabled when sleep is 0 and disabled when sleep is 1. A disabled input reads as 0.
- R8: The raw input tap equals the pad input after the input gate, with no register on the path.
- R9: The pin-input register holds the raw tap as sampled two clock edges earlier.
- R10: The register map is as follows. Offset 0 is the pin-input register, and writes to it are ignored. Offset 1 is direction. Offset 2 is port. Offset 3 reads 0. A read strobe loads rdata at the clock edge, and rdata holds its value otherwise.
- R11: A synchronous active-high reset clears direction, port, the synchronizer and rdata to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pull_dis | input | 1 | Shared pull-up disable |
| sleep | input | 1 | Shared sleep indication |
| pu_ovr_en | input | 8 | Per-pin pull-up override enable |
| pu_ovr_val | input | 8 | Per-pin pull-up override value |
| oe_ovr_en | input | 8 | Per-pin output-enable override enable |
| oe_ovr_val | input | 8 | Per-pin output-enable override value |
| dv_ovr_en | input | 8 | Per-pin driven-value override enable |
| dv_ovr_val | input | 8 | Per-pin driven-value override value |
| tog_req | input | 8 | Per-pin port-bit toggle request |
| ie_ovr_en | input | 8 | Per-pin input-enable override enable |
| ie_ovr_val | input | 8 | Per-pin input-enable override value |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad driven values |
| pad_oe | output | 8 | Pad output enables |
| pad_pullup | output | 8 | Pad pull-up requests |
| raw_din | output | 8 | Gated, unsynchronized input tap |

## Verification
The bench builds the port with its defaults: eight pins and a two-stage synchronizer. With two stages, the latency of the input register can be probed edge by edge. A read held across two edges must still return the old level, and the third edge must bring the new one.

The override patterns are broadcast to all eight pins, so each table row checks every pin's multiplexing at once. Toggling is exercised on single bits and on the whole byte. This makes the single-cycle inversion, repeated inversion and the case where a write collides with a toggle all reachable.

// File: rtl/altpin_pkg.sv
package altpin_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    OFS_PIN  = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_PORT = 2'd2
  } reg_ofs_e;
endpackage

// File: rtl/altpin_regs.sv
module altpin_regs
  import altpin_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      tog,
  input  logic [N-1:0]      pin_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      port_q,
  output logic [N-1:0]      rdata
);
  logic wr_dir, wr_port;
  assign wr_dir  = wr && (addr == OFS_DIR);
  assign wr_port = wr && (addr == OFS_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      port_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_port) port_q <= wdata;      // bus write has priority over toggles
      else         port_q <= port_q ^ tog;
      if (rd) begin
        case (addr)
          OFS_PIN:  rdata <= pin_q;
          OFS_DIR:  rdata <= dir_q;
          OFS_PORT: rdata <= port_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    !wr_port |=> (port_q ^ $past(port_q)) == $past(tog)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_port |=> port_q == $past(wdata)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R10
endmodule

// File: rtl/altpin_cell.sv
module altpin_cell (
  input  logic dir_bit,
  input  logic port_bit,
  input  logic pull_dis,
  input  logic sleep,
  input  logic pu_en,
  input  logic pu_val,
  input  logic oe_en,
  input  logic oe_val,
  input  logic dv_en,
  input  logic dv_val,
  input  logic ie_en,
  input  logic ie_val,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pullup,
  output logic din
);
  logic in_on;

  always_comb begin
    pad_pullup = pu_en ? pu_val : (!dir_bit && port_bit && !pull_dis);
    pad_oe     = oe_en ? oe_val : dir_bit;
    pad_out    = dv_en ? dv_val : port_bit;
    in_on      = ie_en ? ie_val : !sleep;
    din        = pad_in && in_on;
  end
endmodule

// File: rtl/altpin_sync.sv
module altpin_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_LAT: assert property (@(posedge clk) disable iff (rst || $past(rst) || $past(rst, 2))
        q == $past(d, 2)); // R9
    end
  endgenerate
endmodule

// File: rtl/altpin_port.sv
module altpin_port
  import altpin_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic              pull_dis,
  input  logic              sleep,
  input  logic [N-1:0]      pu_ovr_en,
  input  logic [N-1:0]      pu_ovr_val,
  input  logic [N-1:0]      oe_ovr_en,
  input  logic [N-1:0]      oe_ovr_val,
  input  logic [N-1:0]      dv_ovr_en,
  input  logic [N-1:0]      dv_ovr_val,
  input  logic [N-1:0]      tog_req,
  input  logic [N-1:0]      ie_ovr_en,
  input  logic [N-1:0]      ie_ovr_val,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  output logic [N-1:0]      pad_pullup,
  output logic [N-1:0]      raw_din
);
  logic [N-1:0] dir_q, port_q, pin_q;

  altpin_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .tog(tog_req), .pin_q(pin_q),
    .dir_q(dir_q), .port_q(port_q), .rdata(bus_rdata)
  );

  altpin_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_din), .q(pin_q)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_pin
      altpin_cell u_cell (
        .dir_bit(dir_q[g]), .port_bit(port_q[g]),
        .pull_dis(pull_dis), .sleep(sleep),
        .pu_en(pu_ovr_en[g]), .pu_val(pu_ovr_val[g]),
        .oe_en(oe_ovr_en[g]), .oe_val(oe_ovr_val[g]),
        .dv_en(dv_ovr_en[g]), .dv_val(dv_ovr_val[g]),
        .ie_en(ie_ovr_en[g]), .ie_val(ie_ovr_val[g]),
        .pad_in(pad_in[g]),
        .pad_oe(pad_oe[g]), .pad_out(pad_out[g]),
        .pad_pullup(pad_pullup[g]), .din(raw_din[g])
      );

      AST_PUD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!pu_ovr_en[g] && pull_dis) |-> !pad_pullup[g]); // R1
      AST_PU_OVR: assert property (@(posedge clk) disable iff (rst)
        pu_ovr_en[g] |-> pad_pullup[g] == pu_ovr_val[g]); // R2
      AST_OE_OVR: assert property (@(posedge clk) disable iff (rst)
        oe_ovr_en[g] |-> pad_oe[g] == oe_ovr_val[g]); // R3
      AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
        (!ie_ovr_en[g] && sleep) |-> !raw_din[g]); // R7
    end
  endgenerate
endmodule

// File: tb/test_altpin_port.sv
`timescale 1ns/1ps
module test_altpin_port;
  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic pull_dis = 0, sleep = 0;
  logic [7:0] pu_ovr_en = 0, pu_ovr_val = 0, oe_ovr_en = 0, oe_ovr_val = 0;
  logic [7:0] dv_ovr_en = 0, dv_ovr_val = 0, tog_req = 0, ie_ovr_en = 0, ie_ovr_val = 0;
  logic [7:0] pad_in = 0, pad_out, pad_oe, pad_pullup, raw_din;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  altpin_port i_altpin_port (.*);

  // {dir,port,pud,pu_en,pu_val,oe_en,oe_val,dv_en,dv_val, exp_pu,exp_oe,exp_out}
  localparam logic [11:0] VEC [10] = '{
    12'b0_1_0_0_0_0_0_0_0_1_0_1,
    12'b0_1_1_0_0_0_0_0_0_0_0_1,
    12'b1_1_0_0_0_0_0_0_0_0_1_1,
    12'b0_0_0_0_0_0_0_0_0_0_0_0,
    12'b1_0_0_1_1_0_0_0_0_1_1_0,
    12'b0_1_0_1_0_0_0_0_0_0_0_1,
    12'b1_0_0_0_0_1_0_0_0_0_0_0,
    12'b0_0_0_0_0_1_1_1_1_0_1_1,
    12'b1_1_0_0_0_0_0_1_0_0_1_0,
    12'b0_1_1_1_1_1_1_0_0_1_1_1
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 oe", pad_oe, 8'h00);
    rd_reg(2'd1, r); check("R11 dir", r, 8'h00);
    rd_reg(2'd2, r); check("R11 port", r, 8'h00);
    rd_reg(2'd0, r); check("R11 pin", r, 8'h00);

    // table: R1 R2 R3 R4 broadcast to all pins
    foreach (VEC[i]) begin
      wr_reg(2'd1, {8{VEC[i][11]}});
      wr_reg(2'd2, {8{VEC[i][10]}});
      @(negedge clk);
      pull_dis = VEC[i][9];
      pu_ovr_en = {8{VEC[i][8]}}; pu_ovr_val = {8{VEC[i][7]}};
      oe_ovr_en = {8{VEC[i][6]}}; oe_ovr_val = {8{VEC[i][5]}};
      dv_ovr_en = {8{VEC[i][4]}}; dv_ovr_val = {8{VEC[i][3]}};
      #1;
      check("R1/R2 pullup", pad_pullup, {8{VEC[i][2]}});
      check("R3 oe", pad_oe, {8{VEC[i][1]}});
      check("R4 out", pad_out, {8{VEC[i][0]}});
    end
    @(negedge clk);
    pull_dis = 0; pu_ovr_en = 0; oe_ovr_en = 0; dv_ovr_en = 0;
    pu_ovr_val = 0; oe_ovr_val = 0; dv_ovr_val = 0;

    // R1 per-pin mix: dir 0x0F, port 0x3C -> pullup on bits 4,5
    wr_reg(2'd1, 8'h0F); wr_reg(2'd2, 8'h3C);
    check("R1 mix", pad_pullup, 8'h30);
    check("R3 mix", pad_oe, 8'h0F);
    // R10 readback and ignored write at offset 0
    rd_reg(2'd1, r); check("R10 dir", r, 8'h0F);
    rd_reg(2'd2, r); check("R10 port", r, 8'h3C);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, r); check("R10 pin ro", r, 8'h00);
    rd_reg(2'd1, r); check("R10 dir kept", r, 8'h0F);
    rd_reg(2'd3, r); check("R10 ofs3", r, 8'h00);

    // R5 toggle
    wr_reg(2'd2, 8'h00);
    @(negedge clk); tog_req = 8'h01;
    @(negedge clk); tog_req = 8'h00;
    rd_reg(2'd2, r); check("R5 single", r, 8'h01);
    @(negedge clk); tog_req = 8'h81;
    repeat (3) @(negedge clk);
    tog_req = 8'h00;
    rd_reg(2'd2, r); check("R5 triple", r, 8'h80);
    // R6 write beats toggle
    @(negedge clk); tog_req = 8'hFF; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h0F;
    @(negedge clk); tog_req = 8'h00; bus_wr = 0;
    rd_reg(2'd2, r); check("R6 write wins", r, 8'h0F);

    // R8 raw tap, R9 sync latency
    @(negedge clk); pad_in = 8'hA5; #1;
    check("R8 raw", raw_din, 8'hA5);
    bus_rd = 1; bus_addr = 2'd0;
    @(negedge clk); check("R9 edge1", bus_rdata, 8'h00);
    @(negedge clk); check("R9 edge2", bus_rdata, 8'h00);
    @(negedge clk); check("R9 edge3", bus_rdata, 8'hA5);
    bus_rd = 0;
    @(negedge clk); check("R10 hold", bus_rdata, 8'hA5);

    // R7 input enable
    sleep = 1; #1; check("R7 sleep off", raw_din, 8'h00);
    ie_ovr_en = 8'h0F; ie_ovr_val = 8'h0F; #1;
    check("R7 ovr on in sleep", raw_din, 8'h05);
    @(negedge clk); sleep = 0; ie_ovr_en = 8'hF0; ie_ovr_val = 8'h00; #1;
    check("R7 ovr off awake", raw_din, 8'h05);
    repeat (3) @(negedge clk);
    rd_reg(2'd0, r); check("R7 pin reads 0", r, 8'h05);

    // R11 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd_reg(2'd2, r); check("R11 port cleared", r, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule